// File: doc/BRIEF.md
# Single-Word SDRAM Controller

This block sits between a simple word-addressed processor port and a synchronous DRAM. The DRAM is made of two 16-bit devices wired side by side, so the data path is 32 bits wide. The controller runs on the DRAM clock. After reset it brings the memory up: a power-up pause, a precharge of all banks, two refresh cycles and the mode-register load. It then serves one 32-bit word for each request. Each access opens the row and then issues a read or write that closes the row again by itself, so normal traffic needs no separate precharge command. In the background, a down-counter keeps track of refresh debt, and the controller pays that debt whenever it is idle.

The processor raises `req` together with `wr`, `addr` and, for a write, `wdata`. The controller samples them on the rising edge of the clock. `stall` then stays high for every cycle of the access except the last one. For a read, `rdata` holds the word from the edge on which `stall` falls. The spacing between commands is set by cycle-count parameters, so the same block can be configured for a slow clock or a fast one.

Top module: `sdram_word_ctrl`

## Requirements
- R1: After reset, `stall` stays high and requests are ignored until initialization ends. Initialization issues PRECHARGE (A10 high) in cycle T_PWR+1 after reset is released, then AUTO REFRESH twice, then LOAD MODE. Commands are encoded on {cs_n,ras_n,cas_n,we_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000.
- R2: LOAD MODE drives `dram_a` = 12'h220 (write bursts of one word, CAS latency 2, sequential, burst length 1) and `dram_ba` = 0.
- R3: The word address maps as follows. `dram_ba` = addr[22:21]. ACTIVE carries row = addr[20:9]. READ and WRITE carry column = addr[8:0] on `dram_a[8:0]`, with `dram_a[10]` high to request auto-precharge.
- R4: READ or WRITE follows its ACTIVE after exactly T_RCD cycles, and only to the bank that ACTIVE opened. ACTIVE is never issued to a bank that is still open, and AUTO REFRESH is issued only with all banks closed.
- R5: For a read, `stall` is high for T_RCD+3 cycles after the accepting edge. When it falls, `rdata` holds the last word written to that address, or the memory's existing content if the address was never written.
- R6: For a write, `stall` is high for T_RCD+1 cycles after the accepting edge. `dq` carries `wdata` when WRITE is sampled, and `stall` is low in the cycle after WRITE.
- R7: The controller drives `dq` only in the WRITE command cycle and leaves it released at all other times, including the whole read return.
- R8: Once LOAD MODE has been sampled, a refresh tick occurs every REF_CYCLES cycles. Over an idle span, the number of AUTO REFRESH commands equals the number of ticks, or one fewer while the latest tick is still being served.
- R9: A tick that is pending when a request would be accepted is served first, so no ACTIVE is issued while refresh debt from earlier cycles is outstanding. The pending count never wraps from its maximum to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 23 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid when `stall` falls after a read |
| stall | output | 1 | High while the controller cannot complete or accept an access |
| dq | inout | 32 | DRAM data bus |
| dram_a | output | 12 | Multiplexed row/column address |
| dram_ba | output | 2 | Bank select |
| cke | output | 1 | Clock enable, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dqm | output | 2 | Byte masks shared by both devices, high until initialization ends |

## Verification
The properties assume that `req` is raised only in a cycle where `stall` is low outside the final cycle of an access. They also assume that `wr`, `addr` and `wdata` are stable at the accepting edge. The bench keeps to this by raising `req` only after it has seen the controller idle at a falling edge, and by dropping it one cycle later. The exception is the deliberate request held during initialization, which must be ignored. The bench also assumes that the memory returns read data two edges after READ. Its memory model follows that latency exactly.

// File: rtl/sdram_word_ctrl.sv
module sdram_word_ctrl #(
  parameter int T_PWR      = 2500,
  parameter int T_RP       = 1,
  parameter int T_RCD      = 1,
  parameter int T_RC       = 3,
  parameter int T_MRD      = 2,
  parameter int T_WR       = 1,
  parameter int REF_CYCLES = 390,
  parameter int PEND_W     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        wr,
  input  logic [22:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        stall,
  inout  wire  [31:0] dq,
  output logic [11:0] dram_a,
  output logic [1:0]  dram_ba,
  output logic        cke,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  dqm
);
  localparam int DW  = $clog2(T_PWR + T_RC + T_WR + T_RP + T_RCD + T_MRD + 4) + 1;
  localparam int RCW = $clog2(REF_CYCLES + 1);
  localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};
  localparam logic [11:0] MODE_WORD = 12'h220;

  typedef enum logic [3:0] {
    S_WAIT, S_PRE, S_RFI1, S_RFI2, S_MRS, S_IDLE, S_REF, S_ACT, S_RW, S_DONE
  } st_t;

  st_t st, after, tgt;
  logic [DW-1:0]     cnt, gap;
  logic              go;
  logic [RCW-1:0]    ref_cnt;
  logic [PEND_W-1:0] pend;
  logic              init_done, op_wr, dq_oe, tick, take;
  logic [22:0]       op_addr;
  logic [31:0]       op_data;
  logic [3:0]        cmd;

  assign take  = (st == S_IDLE) && (pend == '0) && req;
  assign tick  = init_done && (ref_cnt == '0);
  assign stall = !(((st == S_IDLE) && (pend == '0)) || (st == S_DONE));
  assign dq_oe = (st == S_RW) && op_wr;
  assign dq    = dq_oe ? op_data : 'z;
  assign cke   = 1'b1;
  assign dqm   = init_done ? 2'b00 : 2'b11;
  assign {cs_n, ras_n, cas_n, we_n} = cmd;

  always_comb begin
    go  = 1'b1;
    tgt = S_IDLE;
    gap = '0;
    case (st)
      S_PRE:  begin tgt = S_RFI1; gap = DW'(T_RP - 1);  end
      S_RFI1: begin tgt = S_RFI2; gap = DW'(T_RC - 1);  end
      S_RFI2: begin tgt = S_MRS;  gap = DW'(T_RC - 1);  end
      S_MRS:  begin tgt = S_IDLE; gap = DW'(T_MRD - 1); end
      S_IDLE: begin
        go  = (pend != '0) || req;
        tgt = (pend != '0) ? S_REF : S_ACT;
      end
      S_REF:  begin tgt = S_IDLE; gap = DW'(T_RC - 1);  end
      S_ACT:  begin tgt = S_RW;   gap = DW'(T_RCD - 1); end
      S_RW:   begin tgt = S_DONE; gap = op_wr ? '0 : DW'(2); end
      S_DONE: begin tgt = S_IDLE; gap = op_wr ? DW'(T_WR + T_RP) : DW'(T_RP); end
      default: go = 1'b0;
    endcase
  end

  always_comb begin
    cmd     = 4'b0111;
    dram_a  = '0;
    dram_ba = '0;
    case (st)
      S_PRE:                begin cmd = 4'b0010; dram_a = 12'h400; end
      S_RFI1, S_RFI2, S_REF: cmd = 4'b0001;
      S_MRS:                begin cmd = 4'b0000; dram_a = MODE_WORD; end
      S_ACT: begin
        cmd     = 4'b0011;
        dram_a  = op_addr[20:9];
        dram_ba = op_addr[22:21];
      end
      S_RW: begin
        cmd     = op_wr ? 4'b0100 : 4'b0101;
        dram_a  = {2'b01, 1'b0, op_addr[8:0]};
        dram_ba = op_addr[22:21];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_WAIT;
      after     <= S_PRE;
      cnt       <= DW'(T_PWR - 1);
      ref_cnt   <= RCW'(REF_CYCLES - 1);
      pend      <= '0;
      init_done <= 1'b0;
      op_wr     <= 1'b0;
      op_addr   <= '0;
      op_data   <= '0;
      rdata     <= '0;
    end else begin
      if (st == S_WAIT) begin
        if (cnt == '0) st <= after;
        else           cnt <= cnt - 1'b1;
      end else if (go) begin
        if (gap == '0) st <= tgt;
        else begin
          st    <= S_WAIT;
          after <= tgt;
          cnt   <= gap - 1'b1;
        end
      end
      if (take) begin
        op_wr   <= wr;
        op_addr <= addr;
        op_data <= wdata;
      end
      if (st == S_WAIT && cnt == '0 && after == S_DONE) rdata <= dq;
      if (st == S_MRS) init_done <= 1'b1;
      if (!init_done || tick) ref_cnt <= RCW'(REF_CYCLES - 1);
      else                    ref_cnt <= ref_cnt - 1'b1;
      case ({tick && pend != PMAX, st == S_REF})
        2'b10:   pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdram_word_ctrl_chk.sv
module sdram_word_ctrl_chk #(
  parameter int T_RCD  = 1,
  parameter int PEND_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic [3:0]        cmd,
  input logic [11:0]       a,
  input logic [1:0]        ba,
  input logic              dq_oe,
  input logic [PEND_W-1:0] pend
);
  logic       mrs_seen;
  logic [7:0] since_act;
  wire        rw_cmd = (cmd == 4'b0101) || (cmd == 4'b0100);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mrs_seen  <= 1'b0;
      since_act <= '0;
    end else begin
      if (cmd == 4'b0000) mrs_seen <= 1'b1;
      if (cmd == 4'b0011) since_act <= 8'd1;
      else if (since_act != '0 && since_act != 8'hFF) since_act <= since_act + 8'd1;
    end
  end

  p_init_stall_r1: assert property (@(posedge clk) disable iff (!rst_n) !mrs_seen |-> stall);
  p_mode_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000) |-> (a == 12'h220 && ba == 2'b00));
  p_auto_pre_r3: assert property (@(posedge clk) disable iff (!rst_n) rw_cmd |-> a[10]);
  p_rcd_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rw_cmd |-> (since_act == 8'(T_RCD)));
  p_wr_last_r6: assert property (@(posedge clk) disable iff (!rst_n) (cmd == 4'b0100) |=> !stall);
  p_bus_drive_r7: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> (cmd == 4'b0100));
  p_bus_release_r7: assert property (@(posedge clk) disable iff (!rst_n) (cmd == 4'b0101) |=> !dq_oe);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == {PEND_W{1'b1}}) |=> (pend != '0));
  p_ref_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0011) |-> ($past(pend) == '0));
endmodule

bind sdram_word_ctrl sdram_word_ctrl_chk #(.T_RCD(T_RCD), .PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .cmd({cs_n, ras_n, cas_n, we_n}),
  .a(dram_a), .ba(dram_ba), .dq_oe(dq_oe), .pend(pend)
);

// File: tb/sdram_word_ctrl_tb_top.sv
module sdram_word_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int T_PWR = 20, T_RP = 1, T_RCD = 2, T_RC = 3, T_MRD = 2, T_WR = 1;
  localparam int REF_T = 60;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, wr = 1'b0;
  logic [22:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic stall, cke, cs_n, ras_n, cas_n, we_n;
  logic [11:0] dram_a;
  logic [1:0] dram_ba, dqm;
  wire  [31:0] dq;

  always #(CLK_P/2) clk = ~clk;

  sdram_word_ctrl #(.T_PWR(T_PWR), .T_RP(T_RP), .T_RCD(T_RCD), .T_RC(T_RC), .T_MRD(T_MRD),
    .T_WR(T_WR), .REF_CYCLES(REF_T), .PEND_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata),
    .stall(stall), .dq(dq), .dram_a(dram_a), .dram_ba(dram_ba), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dqm(dqm));

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int k);
    return 32'(k) * 32'h9E37_79B9 + 32'h0123_4567;
  endfunction

  // memory model
  logic [31:0] mem [int];
  logic [31:0] ref_mem [int];
  logic m_oe = 1'b0, rq0 = 1'b0;
  logic [31:0] m_dq = '0, rq0_dat = '0;
  assign dq = m_oe ? m_dq : 'z;

  int cyc = 0, init_idx = 0, mrs_cyc = 0, refs = 0, act_cyc = 0;
  bit mrs_seen = 1'b0;
  bit open_b [4];
  logic [11:0] row_b [4];
  logic [22:0] exp_addr = '0;
  logic [31:0] exp_d = '0;

  always @(posedge clk) begin
    logic [3:0] c;
    int k;
    if (!rst_n) begin
      cyc = 0;
    end else begin
      cyc = cyc + 1;
      m_oe <= rq0;
      m_dq <= rq0_dat;
      rq0  <= 1'b0;
      c = {cs_n, ras_n, cas_n, we_n};
      case (c)
        4'b0111: ;
        4'b0010: begin
          if (!mrs_seen) begin
            chk(init_idx == 0, "R1 precharge order", init_idx, 0);
            chk(cyc == T_PWR + 1, "R1 power-up delay", cyc, T_PWR + 1);
            chk(dram_a[10], "R1 precharge all", dram_a, 12'h400);
            init_idx++;
          end
          for (int b = 0; b < 4; b++) open_b[b] = 1'b0;
        end
        4'b0001: begin
          if (!mrs_seen) begin
            chk(init_idx == 1 || init_idx == 2, "R1 init refresh order", init_idx, 1);
            init_idx++;
          end else refs++;
          chk(!(open_b[0] || open_b[1] || open_b[2] || open_b[3]), "R4 refresh with bank open", 1, 0);
        end
        4'b0000: begin
          chk(init_idx == 3, "R1 load mode order", init_idx, 3);
          chk(dram_a == 12'h220 && dram_ba == 2'b00, "R2 mode word", {dram_ba, dram_a}, 12'h220);
          init_idx++;
          mrs_seen = 1'b1;
          mrs_cyc = cyc;
        end
        4'b0011: begin
          chk(mrs_seen, "R1 access during init", 0, 1);
          chk(!open_b[dram_ba], "R4 activate open bank", dram_ba, 0);
          chk({dram_ba, dram_a} == exp_addr[22:9], "R3 row/bank", {dram_ba, dram_a}, exp_addr[22:9]);
          chk((cyc - 2 - mrs_cyc) / REF_T <= refs, "R9 refresh owed at activate", refs, (cyc - 2 - mrs_cyc) / REF_T);
          open_b[dram_ba] = 1'b1;
          row_b[dram_ba] = dram_a;
          act_cyc = cyc;
        end
        4'b0101, 4'b0100: begin
          chk(open_b[dram_ba], "R4 access to closed bank", dram_ba, 0);
          chk(cyc - act_cyc == T_RCD, "R4 activate to column gap", cyc - act_cyc, T_RCD);
          chk(dram_a[10] && dram_a[8:0] == exp_addr[8:0] && dram_ba == exp_addr[22:21],
              "R3 column", {dram_ba, dram_a}, {exp_addr[22:21], 3'b010, exp_addr[8:0]});
          k = int'({dram_ba, row_b[dram_ba], dram_a[8:0]});
          if (c == 4'b0100) begin
            chk(dq == exp_d, "R6 write data on bus", dq, exp_d);
            mem[k] = dq;
          end else begin
            rq0     <= 1'b1;
            rq0_dat <= mem.exists(k) ? mem[k] : pat(k);
          end
          open_b[dram_ba] = 1'b0;
        end
        default: chk(0, "R1 illegal command", c, 4'b0111);
      endcase
    end
  end

  task automatic access(input logic w, input logic [22:0] ad, input logic [31:0] d);
    int n = 0;
    int k = int'(ad);
    logic [31:0] e;
    while (stall) @(negedge clk);
    req = 1'b1; wr = w; addr = ad; wdata = d;
    exp_addr = ad; exp_d = d;
    e = ref_mem.exists(k) ? ref_mem[k] : pat(k);
    @(negedge clk);
    req = 1'b0;
    while (stall && n < 100) begin n++; @(negedge clk); end
    if (w) begin
      chk(n == T_RCD + 1, "R6 write stall length", n, T_RCD + 1);
      ref_mem[k] = d;
    end else begin
      chk(n == T_RCD + 3, "R5 read stall length", n, T_RCD + 3);
      chk(rdata == e, "R5 R7 read data", rdata, e);
    end
    @(negedge clk);
  endtask

  task automatic check_refresh(input string tag);
    int k = cyc - mrs_cyc;
    int e = k / REF_T;
    chk(refs == e || refs == e - 1, tag, refs, e);
  endtask

  initial begin
    logic [31:0] x = 32'h1357_9BDF;
    logic [22:0] ad;
    repeat (4) @(negedge clk);
    chk(stall, "R1 stall in reset", stall, 1);
    rst_n = 1'b1;
    req = 1'b1; wr = 1'b1; addr = 23'h00_0123; wdata = 32'hFFFF_0000;
    for (int i = 0; i < T_PWR - 2; i++) begin
      @(negedge clk);
      chk(stall, "R1 stall during init", stall, 1);
    end
    req = 1'b0;
    while (stall) @(negedge clk);
    chk(init_idx == 4, "R1 init complete", init_idx, 4);
    chk(dqm == 2'b00, "R1 masks released", dqm, 0);

    for (int pass = 0; pass < 3; pass++)
      for (int b = 0; b < 4; b++)
        for (int r = 0; r < 2; r++)
          for (int c = 0; c < 2; c++) begin
            ad = {2'(b), r ? 12'hFFF : 12'h000, c ? 9'h1FF : 9'h000};
            access(pass == 1, ad, pat(int'(ad)) ^ 32'hA5A5_0F0F ^ 32'(b * 7 + r * 3 + c));
          end
    access(1'b1, 23'h2A_5555, 32'h1111_2222);
    access(1'b1, 23'h2A_5555, 32'h3333_4444);
    access(1'b0, 23'h2A_5555, 32'h0);

    repeat (5 * REF_T) @(negedge clk);
    repeat (T_RC + 4) @(negedge clk);
    check_refresh("R8 idle refresh count");

    for (int i = 0; i < 240; i++) begin
      x = x * 32'd1103515245 + 32'd12345;
      ad = {x[21:20], 8'h00, x[19:16], 4'h0, x[15:11]};
      access(x[5], ad, x ^ 32'h5A5A_5A5A);
    end
    repeat (T_RC * 3 + 4) @(negedge clk);
    check_refresh("R8 R9 refresh after traffic");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule